// File: doc/BRIEF.md
# DMA Channel Teardown Sequencer

This block holds the per-channel control words of a descriptor-based packet DMA and runs the shutdown sequence of a channel. Every port has one transmit and one receive channel. Each channel has its own 32-bit configuration word. Software sets the enable, the starvation-retry option, the host-descriptor mode and the number of the completion queue through a simple write port, and reads the word back through a read port. The DMA engine opens transfers with a start strobe and closes them with a done strobe. The block tracks the single in-flight descriptor of each channel. On completion it pushes that descriptor to the channel's completion queue.

When software asks for a teardown, the channel stops taking new work. If a descriptor is in flight, the block pushes it back to the channel's completion queue first. It then pushes a typed marker word to a dedicated teardown queue. A busy transmit channel only accepts a teardown once the request has been repeated a set number of times. A receive channel accepts it at once. All queue pushes from all channels share one registered valid/queue/data output, and the lowest channel index wins when several channels want to push in the same cycle.

Top module: `dma_td_ctrl`

## Requirements
- R1: After reset every configuration word reads as zero, `fetch_en` and `td_busy` are all zero and `push_valid` is low.
- R2: Port p's transmit word lies at byte address p*0x20 and its receive word at p*0x20+8. Channel index is 2*p for transmit and 2*p+1 for receive. Word fields are: bit 31 enable, bit 30 teardown, bit 24 starvation retry, bit 14 host mode, bits QW-1:0 completion queue. All other bits read as zero. A write to any other offset, or to a port at or above NUM_PORTS, changes nothing.
- R3: `fetch_en` of a channel is high exactly when the channel is enabled and not tearing down. A start on a channel with `fetch_en` low, or on a channel that already holds a descriptor, is ignored.
- R4: A done strobe sampled at clock edge k on a busy channel that is not tearing down makes the held descriptor appear on the push port after edge k+1, with the channel's completion queue.
- R5: The teardown marker is pushed to queue TD_Q. Bits 31:27 hold type 0x13, bit 16 is set for a receive channel, bits 4:0 hold the port number, and all other bits are zero.
- R6: A teardown accepted at edge k on a channel holding a descriptor pushes that descriptor to the completion queue after edge k+1, and the marker after edge k+2.
- R7: A teardown of a channel with no descriptor in flight pushes only the marker, after edge k+1.
- R8: While a transmit channel holds a descriptor, it ignores the first TX_TD_TRIES-1 teardown writes. After each ignored write, bit 30 reads as zero and `td_busy` stays low.
- R9: A receive channel accepts the first teardown write even while it holds a descriptor.
- R10: `td_busy` and bit 30 are set from acceptance until the marker is pushed, and clear in the same cycle the marker is pushed. The enable bit stays set until software writes zero, which drops `fetch_en`.
- R11: When several channels have a push pending in the same cycle, the lowest channel index is pushed first, and one push leaves per cycle.
- R12: Configuration writes to a channel while its teardown is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | AW | Configuration write byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | AW | Configuration read byte address |
| cfg_rdata | output | 32 | Configuration word read back (combinational) |
| xfer_start | input | 1 | Engine opens a transfer |
| xfer_chan | input | CH_W | Channel of the start strobe |
| xfer_desc | input | 32 | Descriptor address of the new transfer |
| xfer_done | input | 1 | Engine finished a transfer |
| xfer_done_chan | input | CH_W | Channel of the done strobe |
| fetch_en | output | NCH | Channel may fetch new work |
| td_busy | output | NCH | Teardown in progress per channel |
| push_valid | output | 1 | Queue push this cycle |
| push_queue | output | QW | Target queue number |
| push_data | output | 32 | Descriptor or marker word pushed |

## Verification
The bench builds the block with three ports, giving six channels and a non-power-of-two channel count. It uses an 8-bit queue field, TX_TD_TRIES of 2 and teardown queue 31. Three ports put the 0x20 stride and the receive offset within reach, along with an invalid offset inside a port window. A repeat count of 2 exposes exactly one ignored transmit request before acceptance. The six channels let a completion push and a marker push fall due in the same cycle, so the fixed-priority arbitration and the one-push-per-cycle ordering can be observed.

// File: rtl/dma_td_pkg.sv
package dma_td_pkg;
   localparam logic [4:0] MARK_TYPE = 5'h13;
   localparam int         BIT_EN    = 31;
   localparam int         BIT_TD    = 30;
   localparam int         BIT_RETRY = 24;
   localparam int         BIT_HOST  = 14;

   function automatic logic [31:0] td_marker(input logic is_rx, input logic [4:0] port);
      logic [31:0] w;
      w        = '0;
      w[31:27] = MARK_TYPE;
      w[16]    = is_rx;
      w[4:0]   = port;
      return w;
   endfunction
endpackage

// File: rtl/dma_td_chan.sv
module dma_td_chan
   import dma_td_pkg::*;
#(
   parameter int          QW          = 8,
   parameter bit          IS_RX       = 1'b0,
   parameter int          PORT        = 0,
   parameter int          TX_TD_TRIES = 2,
   parameter logic [QW-1:0] TD_Q      = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_en_bit,
   input  logic          wr_td_bit,
   input  logic          wr_retry,
   input  logic          wr_host,
   input  logic [QW-1:0] wr_cq,
   input  logic          start,
   input  logic [31:0]   start_desc,
   input  logic          done,
   input  logic          grant,
   output logic [31:0]   rd_word,
   output logic          fetch_en,
   output logic          td_busy,
   output logic          req,
   output logic [QW-1:0] req_q,
   output logic [31:0]   req_data
);
   localparam int CW = (TX_TD_TRIES > 1) ? $clog2(TX_TD_TRIES) : 1;
   localparam logic [CW-1:0] LAST_TRY = CW'(TX_TD_TRIES - 1);

   logic          en_q, td_q, retry_q, host_q, busy_q, fin_q;
   logic [QW-1:0] cq_q;
   logic [31:0]   desc_q;
   logic [CW-1:0] tries_q;
   logic          td_req, td_accept, ret_req, mark_req;

   assign fetch_en  = en_q && !td_q;
   assign td_busy   = td_q;
   assign ret_req   = busy_q && (fin_q || td_q);
   assign mark_req  = td_q && !busy_q;
   assign req       = ret_req || mark_req;
   assign req_q     = ret_req ? cq_q : TD_Q;
   assign req_data  = ret_req ? desc_q : td_marker(IS_RX, 5'(PORT));
   assign td_req    = wr_en && !td_q && wr_en_bit && wr_td_bit;

   generate
      if (IS_RX) begin : g_rx
         assign td_accept = td_req;
      end else begin : g_tx
         assign td_accept = td_req && (!busy_q || tries_q == LAST_TRY);
      end
   endgenerate

   always_comb begin
      rd_word            = '0;
      rd_word[BIT_EN]    = en_q;
      rd_word[BIT_TD]    = td_q;
      rd_word[BIT_RETRY] = retry_q;
      rd_word[BIT_HOST]  = host_q;
      rd_word[QW-1:0]    = cq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         td_q    <= 1'b0;
         retry_q <= 1'b0;
         host_q  <= 1'b0;
         busy_q  <= 1'b0;
         fin_q   <= 1'b0;
         cq_q    <= '0;
         desc_q  <= '0;
         tries_q <= '0;
      end else begin
         if (wr_en && !td_q) begin
            en_q    <= wr_en_bit;
            retry_q <= wr_retry;
            host_q  <= wr_host;
            cq_q    <= wr_cq;
         end
         if (td_accept) begin
            td_q    <= 1'b1;
            tries_q <= '0;
         end else if (td_req) begin
            tries_q <= tries_q + 1'b1;
         end
         if (start && fetch_en && !busy_q) begin
            busy_q <= 1'b1;
            desc_q <= start_desc;
            fin_q  <= 1'b0;
         end
         if (done && busy_q && !td_q) fin_q <= 1'b1;
         if (grant) begin
            if (ret_req) begin
               busy_q  <= 1'b0;
               fin_q   <= 1'b0;
               tries_q <= '0;
            end else begin
               td_q    <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/dma_td_arb.sv
module dma_td_arb #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         grant[i] = req[i] && !taken;
         taken    = taken || req[i];
      end
   end
endmodule

// File: rtl/dma_td_ctrl.sv
module dma_td_ctrl
   import dma_td_pkg::*;
#(
   parameter int            NUM_PORTS   = 4,
   parameter int            QW          = 8,
   parameter int            TX_TD_TRIES = 2,
   parameter logic [QW-1:0] TD_Q        = QW'(31),
   localparam int           PW          = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int           AW          = PW + 5,
   localparam int           NCH         = 2 * NUM_PORTS,
   localparam int           CH_W        = PW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_waddr,
   input  logic [31:0]     cfg_wdata,
   input  logic [AW-1:0]   cfg_raddr,
   output logic [31:0]     cfg_rdata,
   input  logic            xfer_start,
   input  logic [CH_W-1:0] xfer_chan,
   input  logic [31:0]     xfer_desc,
   input  logic            xfer_done,
   input  logic [CH_W-1:0] xfer_done_chan,
   output logic [NCH-1:0]  fetch_en,
   output logic [NCH-1:0]  td_busy,
   output logic            push_valid,
   output logic [QW-1:0]   push_queue,
   output logic [31:0]     push_data
);
   generate
      if (QW < 1 || QW > 14) begin : g_bad_qw
         $error("QW must lie in 1..14");
      end
      if (NUM_PORTS < 1 || NUM_PORTS > 32) begin : g_bad_ports
         $error("NUM_PORTS must lie in 1..32");
      end
      if (TX_TD_TRIES < 1) begin : g_bad_tries
         $error("TX_TD_TRIES must be at least 1");
      end
   endgenerate

   localparam logic [31:0] USED_MASK = (32'h1 << BIT_EN) | (32'h1 << BIT_TD) |
                                       (32'h1 << BIT_RETRY) | (32'h1 << BIT_HOST) |
                                       ((32'h1 << QW) - 32'h1);

   logic                w_ok, r_ok;
   logic [CH_W-1:0]     w_idx, r_idx;
   logic [NCH-1:0]      ch_req, ch_grant;
   logic [NCH-1:0][QW-1:0] ch_q;
   logic [NCH-1:0][31:0]   ch_data, ch_word;
   logic                unused_wbits;

   assign unused_wbits = ^(cfg_wdata & ~USED_MASK);

   assign w_idx = {cfg_waddr[AW-1:5], cfg_waddr[3]};
   assign r_idx = {cfg_raddr[AW-1:5], cfg_raddr[3]};
   assign w_ok  = cfg_we && (cfg_waddr[4:0] == 5'd0 || cfg_waddr[4:0] == 5'd8) &&
                  (32'(cfg_waddr[AW-1:5]) < NUM_PORTS);
   assign r_ok  = (cfg_raddr[4:0] == 5'd0 || cfg_raddr[4:0] == 5'd8) &&
                  (32'(cfg_raddr[AW-1:5]) < NUM_PORTS);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dma_td_chan #(
            .QW(QW), .IS_RX(1'(i % 2)), .PORT(i / 2),
            .TX_TD_TRIES(TX_TD_TRIES), .TD_Q(TD_Q)
         ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (w_ok && w_idx == CH_W'(i)),
            .wr_en_bit  (cfg_wdata[BIT_EN]),
            .wr_td_bit  (cfg_wdata[BIT_TD]),
            .wr_retry   (cfg_wdata[BIT_RETRY]),
            .wr_host    (cfg_wdata[BIT_HOST]),
            .wr_cq      (cfg_wdata[QW-1:0]),
            .start      (xfer_start && xfer_chan == CH_W'(i)),
            .start_desc (xfer_desc),
            .done       (xfer_done && xfer_done_chan == CH_W'(i)),
            .grant      (ch_grant[i]),
            .rd_word    (ch_word[i]),
            .fetch_en   (fetch_en[i]),
            .td_busy    (td_busy[i]),
            .req        (ch_req[i]),
            .req_q      (ch_q[i]),
            .req_data   (ch_data[i])
         );
      end
   endgenerate

   dma_td_arb #(.N(NCH)) u_arb (.req(ch_req), .grant(ch_grant));

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (r_ok && r_idx == CH_W'(i)) cfg_rdata = ch_word[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_valid <= 1'b0;
         push_queue <= '0;
         push_data  <= '0;
      end else begin
         push_valid <= |ch_req;
         push_queue <= '0;
         push_data  <= '0;
         for (int i = 0; i < NCH; i++) begin
            if (ch_grant[i]) begin
               push_queue <= ch_q[i];
               push_data  <= ch_data[i];
            end
         end
      end
   end
endmodule

// File: rtl/dma_td_ctrl_chk.sv
module dma_td_ctrl_chk #(
   parameter int            NUM_PORTS = 4,
   parameter int            QW        = 8,
   parameter logic [QW-1:0] TD_Q      = QW'(31),
   localparam int           NCH       = 2 * NUM_PORTS
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_we,
   input logic [NCH-1:0] fetch_en,
   input logic [NCH-1:0] td_busy,
   input logic           push_valid,
   input logic [QW-1:0]  push_queue,
   input logic [31:0]    push_data
);
   AST_MARK_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && push_queue == TD_Q) |-> (push_data[31:27] == 5'h13)); // R5

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_c
         AST_NO_FETCH_IN_TD: assert property (@(posedge clk) disable iff (!rst_n)
            td_busy[i] |-> !fetch_en[i]); // R3
         AST_TD_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(td_busy[i]) |-> $past(cfg_we)); // R6
         AST_TD_ENDS_WITH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(td_busy[i]) |-> (push_valid && push_queue == TD_Q &&
                                   push_data[4:0] == 5'(i / 2) &&
                                   push_data[16] == 1'(i % 2))); // R10
      end
   endgenerate
endmodule

bind dma_td_ctrl dma_td_ctrl_chk #(
   .NUM_PORTS(NUM_PORTS), .QW(QW), .TD_Q(TD_Q)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .fetch_en(fetch_en),
   .td_busy(td_busy), .push_valid(push_valid), .push_queue(push_queue),
   .push_data(push_data)
);

// File: tb/dma_td_ctrl_test.sv
`timescale 1ns/1ps
module dma_td_ctrl_test;
   localparam int NP = 3;
   localparam int QW = 8;
   localparam int AW = 7;
   localparam int CHW = 3;
   localparam int NCH = 6;
   localparam logic [7:0] TDQ = 8'd31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic xfer_start = 1'b0;
   logic [CHW-1:0] xfer_chan = '0;
   logic [31:0] xfer_desc = '0;
   logic xfer_done = 1'b0;
   logic [CHW-1:0] xfer_done_chan = '0;
   logic [NCH-1:0] fetch_en, td_busy;
   logic push_valid;
   logic [QW-1:0] push_queue;
   logic [31:0] push_data;

   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   dma_td_ctrl #(.NUM_PORTS(NP), .QW(QW), .TX_TD_TRIES(2), .TD_Q(TDQ)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_desc(xfer_desc),
      .xfer_done(xfer_done), .xfer_done_chan(xfer_done_chan),
      .fetch_en(fetch_en), .td_busy(td_busy), .push_valid(push_valid),
      .push_queue(push_queue), .push_data(push_data));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      cfg_raddr = a;
      #0.2;
      d = cfg_rdata;
   endtask

   task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, "readback", d, exp);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic st(input int ch, input logic [31:0] d);
      @(negedge clk);
      xfer_start = 1'b1; xfer_chan = CHW'(ch); xfer_desc = d;
      @(posedge clk);
      #1;
      xfer_start = 1'b0;
   endtask

   task automatic dn(input int ch);
      @(negedge clk);
      xfer_done = 1'b1; xfer_done_chan = CHW'(ch);
      @(posedge clk);
      #1;
      xfer_done = 1'b0;
   endtask

   task automatic exp_push(input string req, input logic [7:0] q, input logic [31:0] d);
      chk(req, "push_valid", 32'(push_valid), 32'd1);
      chk(req, "push_queue", 32'(push_queue), 32'(q));
      chk(req, "push_data", push_data, d);
   endtask

   task automatic exp_none(input string req);
      chk(req, "no push", 32'(push_valid), 32'd0);
   endtask

   task automatic t_reset();
      for (int p = 0; p < NP; p++) begin
         chk_rd("R1", AW'(p * 32), 32'h0);
         chk_rd("R1", AW'(p * 32 + 8), 32'h0);
      end
      chk("R1", "fetch_en", 32'(fetch_en), 32'h0);
      chk("R1", "td_busy", 32'(td_busy), 32'h0);
      exp_none("R1");
   endtask

   task automatic t_cfg();
      wr(7'h20, 32'h81FF_7F21);
      chk_rd("R2", 7'h20, 32'h8100_4021);
      wr(7'h28, 32'h8000_0045);
      chk_rd("R2", 7'h28, 32'h8000_0045);
      wr(7'h24, 32'h8000_00AA);
      chk_rd("R2", 7'h20, 32'h8100_4021);
      chk_rd("R2", 7'h28, 32'h8000_0045);
      wr(7'h60, 32'h8000_0077);
      chk_rd("R2", 7'h40, 32'h0);
      chk("R3", "fetch_en", 32'(fetch_en), 32'b001100);
   endtask

   task automatic t_normal();
      st(2, 32'hA000_0100);
      dn(2);
      exp_none("R4");
      tick();
      exp_push("R4", 8'h21, 32'hA000_0100);
      tick();
      exp_none("R4");
      st(0, 32'h0000_0055);
      dn(0);
      tick();
      exp_none("R3");
   endtask

   task automatic t_td_idle();
      wr(7'h28, 32'hC000_0045);
      chk("R10", "td_busy set", 32'(td_busy[3]), 32'd1);
      chk("R3", "fetch_en off in teardown", 32'(fetch_en[3]), 32'd0);
      chk_rd("R10", 7'h28, 32'hC000_0045);
      exp_none("R7");
      tick();
      exp_push("R7", TDQ, 32'h9801_0001);
      chk("R10", "td_busy cleared", 32'(td_busy[3]), 32'd0);
      chk_rd("R10", 7'h28, 32'h8000_0045);
      tick();
      exp_none("R7");
      wr(7'h28, 32'h0);
      chk("R10", "disabled", 32'(fetch_en[3]), 32'd0);
   endtask

   task automatic t_td_tx_busy();
      st(2, 32'h0000_00B0);
      st(2, 32'h0000_00EE);
      wr(7'h20, 32'hC100_4021);
      chk("R8", "td_busy after ignored", 32'(td_busy[2]), 32'd0);
      chk_rd("R8", 7'h20, 32'h8100_4021);
      exp_none("R8");
      wr(7'h20, 32'hC100_4021);
      chk("R6", "td_busy accepted", 32'(td_busy[2]), 32'd1);
      chk_rd("R6", 7'h20, 32'hC100_4021);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = 7'h20; cfg_wdata = 32'h0;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      exp_push("R6", 8'h21, 32'h0000_00B0);
      tick();
      exp_push("R6", TDQ, 32'h9800_0001);
      chk("R10", "td_busy cleared", 32'(td_busy[2]), 32'd0);
      chk_rd("R12", 7'h20, 32'h8100_4021);
      wr(7'h20, 32'h0);
      chk_rd("R10", 7'h20, 32'h0);
      chk("R10", "disabled", 32'(fetch_en[2]), 32'd0);
   endtask

   task automatic t_rx_busy();
      wr(7'h48, 32'h8000_0050);
      st(5, 32'h0000_00C0);
      wr(7'h48, 32'hC000_0050);
      chk("R9", "rx accepted first", 32'(td_busy[5]), 32'd1);
      tick();
      exp_push("R9", 8'h50, 32'h0000_00C0);
      tick();
      exp_push("R5", TDQ, 32'h9801_0002);
   endtask

   task automatic t_arb();
      wr(7'h08, 32'h8000_0011);
      wr(7'h40, 32'h8000_0040);
      st(1, 32'h0000_00D0);
      @(negedge clk);
      xfer_done = 1'b1; xfer_done_chan = 3'd1;
      cfg_we = 1'b1; cfg_waddr = 7'h40; cfg_wdata = 32'hC000_0040;
      @(posedge clk);
      #1;
      xfer_done = 1'b0; cfg_we = 1'b0;
      exp_none("R11");
      tick();
      exp_push("R11", 8'h11, 32'h0000_00D0);
      tick();
      exp_push("R11", TDQ, 32'h9800_0002);
      tick();
      exp_none("R11");
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_cfg();
      t_normal();
      t_td_idle();
      t_td_tx_busy();
      t_rx_busy();
      t_arb();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule